// File: doc/BRIEF.md
# SD Host Event Status and Interrupt Unit

This unit gathers the completion and error events of an SD host's command engine and data controller, together with a card-detect input and a write-protect input, and turns them into one status word, a write-one-to-clear register, an interrupt enable mask and a single interrupt line. Each event source raises a one-cycle pulse; the unit keeps it as a sticky status bit until software clears it. The card-detect and write-protect pins are asynchronous; both are synchronized, shown as live levels, and a change of the synchronized card-detect level in either direction is itself recorded as a sticky event.

Software reaches the unit through a plain word-addressed port: word 0 returns status, word 1 takes clear writes, word 2 holds the interrupt mask and word 3 is unused. Read data is registered and comes back one cycle after the read strobe. The interrupt output is registered as well, so it follows the masked status by one cycle.

Top module: `sdh_evt_status_unit`

## Requirements
- R1: After a synchronous reset the sticky bits and the mask are all zero, the interrupt output is low and the read data is zero; the card-detect level is taken as 1 (no card) until the synchronizer has filled.
- R2: A pulse on event input bit k (k from 0 to 9) sets status bit k at the next clock edge, and the bit stays set until cleared. Bit order: 0 response CRC error, 1 data CRC error, 2 response timeout, 3 data timeout, 4 response CRC good, 5 data CRC good, 6 command issued, 7 data done, 8 FIFO underrun, 9 FIFO overrun.
- R3: Status bit 10 becomes set three clock edges after the card-detect pin changes in either direction (two synchronizer stages and one edge-compare stage).
- R4: Status bit 11 shows the synchronized card-detect level (1 means no card) and bit 12 the synchronized write-protect level, each two clock edges after the pin; clear writes have no effect on them and all bits above 12 read 0.
- R5: A write to word 1 clears every sticky bit (0 to 10) whose write-data bit is 1 and leaves the bits written 0 unchanged; write-data bits above 10 are ignored.
- R6: When an event pulse and a clear of the same bit land in the same cycle, the bit ends up set.
- R7: Word 2 is the interrupt mask: a write stores write-data bits 0 to 10, and a read returns them with all higher bits 0.
- R8: The interrupt output is high one cycle after any bit 0 to 10 is both set in status and enabled in the mask, and low one cycle after no such bit exists; a mask of zero keeps it low.
- R9: Read data appears one clock after the read strobe; word 1 and word 3 read as 0.
- R10: The live levels in bits 11 and 12 never raise the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_i | input | 10 | One-cycle event pulses, bit k sets status bit k |
| cd_pin_i | input | 1 | Asynchronous card-detect level, 1 = no card |
| wp_pin_i | input | 1 | Asynchronous write-protect level |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The properties assume that reset is held from time zero until the synchronizers have been loaded, that event inputs are clean single-cycle pulses on the clock, and that read and write strobes are never raised together. The stimulus changes every input only on the falling clock edge, holds each pin level for several cycles so the synchronizer output is a clean step, and issues reads and writes as separate one-cycle strobes. The set-versus-clear collision is produced on purpose by raising an event pulse and a clear write in the same cycle.

// File: rtl/sdh_evt_pkg.sv
package sdh_evt_pkg;
  // Sticky event count and source count (card change is generated inside)
  localparam int EVT_W   = 11;
  localparam int SRC_W   = 10;
  // Bit positions that software decodes
  localparam int CHG_BIT = 10;
  localparam int CD_BIT  = 11;
  localparam int WP_BIT  = 12;
  // Word addresses of the register port
  localparam int ADR_STATUS = 0;
  localparam int ADR_CLEAR  = 1;
  localparam int ADR_MASK   = 2;
endpackage

// File: rtl/sdh_level_sync.sv
module sdh_level_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {STAGES{RST_VAL}};
    end else begin
      chain[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/sdh_cd_watch.sv
module sdh_cd_watch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cd_pin_i,
  output logic cd_lvl_o,
  output logic chg_o
);
  logic cd_prev;

  // No card is assumed while the chain fills after reset
  sdh_level_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cd_sync (
    .clk (clk),
    .rst (rst),
    .d_i (cd_pin_i),
    .q_o (cd_lvl_o)
  );

  always_ff @(posedge clk) begin
    if (rst) cd_prev <= 1'b1;
    else     cd_prev <= cd_lvl_o;
  end

  assign chg_o = cd_lvl_o ^ cd_prev;

  // R3: either edge of the synchronized level flags a change
  p_edge_flag_r3: assert property (@(posedge clk) disable iff (rst)
    ($rose(cd_lvl_o) || $fell(cd_lvl_o)) |-> chg_o);
  // R3: a steady level raises no change
  p_no_edge_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    $stable(cd_lvl_o) |-> !chg_o);
endmodule

// File: rtl/sdh_sticky_bank.sv
module sdh_sticky_bank #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] st_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)           st_o[b] <= 1'b0;
      else if (set_i[b]) st_o[b] <= 1'b1;   // set beats clear
      else if (clr_i[b]) st_o[b] <= 1'b0;
    end

    // R6: a set always lands, even with a clear in the same cycle
    p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
      set_i[b] |=> st_o[b]);
    // R5: a clear without a set empties the bit
    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
      (clr_i[b] && !set_i[b]) |=> !st_o[b]);
    // R2: with no set and no clear the bit holds
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
      (!clr_i[b] && !set_i[b]) |=> $stable(st_o[b]));
  end
endmodule

// File: rtl/sdh_irq_reduce.sv
module sdh_irq_reduce #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] st_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_o
);
  logic [W-1:0] hit;

  assign hit = st_i & mask_i;

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |hit;
  end

  // R8: an enabled pending event raises the line a cycle later
  p_irq_follow_r8: assert property (@(posedge clk) disable iff (rst)
    (|(st_i & mask_i)) |=> irq_o);
  // R8: no enabled pending event drops the line a cycle later
  p_irq_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !(|(st_i & mask_i)) |=> !irq_o);
  // R8: an all-zero mask keeps the line low
  p_mask_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (mask_i == '0) |=> !irq_o);
endmodule

// File: rtl/sdh_evt_status_unit.sv
module sdh_evt_status_unit
  import sdh_evt_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SRC_W-1:0]  evt_i,
  input  logic              cd_pin_i,
  input  logic              wp_pin_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(ADR_STATUS);
  localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(ADR_CLEAR);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(ADR_MASK);

  logic              cd_lvl, wp_lvl, cd_chg;
  logic [EVT_W-1:0]  set_vec, clr_vec, sticky, mask_q;
  logic [DATA_W-1:0] status_word;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata_i[DATA_W-1:EVT_W];

  sdh_cd_watch #(.SYNC_STAGES(SYNC_STAGES)) u_cd_watch (
    .clk      (clk),
    .rst      (rst),
    .cd_pin_i (cd_pin_i),
    .cd_lvl_o (cd_lvl),
    .chg_o    (cd_chg)
  );

  sdh_level_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_wp_sync (
    .clk (clk),
    .rst (rst),
    .d_i (wp_pin_i),
    .q_o (wp_lvl)
  );

  assign set_vec = {cd_chg, evt_i};
  assign clr_vec = (reg_wr_i && reg_addr_i == A_CLEAR) ? reg_wdata_i[EVT_W-1:0] : '0;

  sdh_sticky_bank #(.W(EVT_W)) u_sticky (
    .clk   (clk),
    .rst   (rst),
    .set_i (set_vec),
    .clr_i (clr_vec),
    .st_o  (sticky)
  );

  always_ff @(posedge clk) begin
    if (rst)                                  mask_q <= '0;
    else if (reg_wr_i && reg_addr_i == A_MASK) mask_q <= reg_wdata_i[EVT_W-1:0];
  end

  sdh_irq_reduce #(.W(EVT_W)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .st_i   (sticky),
    .mask_i (mask_q),
    .irq_o  (irq_o)
  );

  always_comb begin
    status_word              = '0;
    status_word[EVT_W-1:0]   = sticky;
    status_word[CD_BIT]      = cd_lvl;
    status_word[WP_BIT]      = wp_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata_o <= '0;
    end else if (reg_rd_i) begin
      if (reg_addr_i == A_STATUS)    reg_rdata_o <= status_word;
      else if (reg_addr_i == A_MASK) reg_rdata_o <= DATA_W'(mask_q);
      else                           reg_rdata_o <= '0;
    end
  end

  // R7: a mask write is what the mask holds next cycle
  p_mask_write_r7: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_i && reg_addr_i == A_MASK) |=> (mask_q == $past(reg_wdata_i[EVT_W-1:0])));
  // R9: the clear word reads back as zero
  p_clear_read_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_i && reg_addr_i == A_CLEAR) |=> (reg_rdata_o == '0));
  // R4: the live write-protect bit in a status read matches the synchronizer
  p_wp_live_r4: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_i && reg_addr_i == A_STATUS) |=> (reg_rdata_o[WP_BIT] == $past(wp_lvl)));
endmodule

// File: tb/test_sdh_evt_status_unit.sv
module test_sdh_evt_status_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  evt = '0;
  logic        cd = 1'b1, wp = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic        rd_seen;
  int          total = 0, bad = 0;
  logic        done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;   // 125 MHz

  sdh_evt_status_unit i_sdh_evt_status_unit (
    .clk(clk), .rst(rst), .evt_i(evt), .cd_pin_i(cd), .wp_pin_i(wp),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  always @(posedge clk) rd_seen <= rd;

  // Monitor: compare each returned read against the scoreboard
  always @(negedge clk) begin
    if (rd_seen === 1'b1) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL %s: unexpected read data %h, expected nothing", "R9", rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          bad++;
          $display("FAIL %s: read %h expected %h", t, rdata, e);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic reg_read(input logic [1:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic pulse(input logic [9:0] v);
    evt = v;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic check_irq(input logic e, input string t);
    total++;
    if (irq !== e) begin
      bad++;
      $display("FAIL %s: irq %b expected %b", t, irq, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(4);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    check_irq(1'b0, "R1");
    reg_read(2'd0, 32'h0000_0800, "R1");
    reg_read(2'd2, 32'h0000_0000, "R1");

    // R2 sticky events, masked off so irq stays low (R8)
    pulse(10'h005);
    reg_read(2'd0, 32'h0000_0805, "R2");
    tick(2);
    check_irq(1'b0, "R8");

    // R7 mask write, upper bits dropped
    reg_write(2'd2, 32'hFFFF_FFFF);
    reg_read(2'd2, 32'h0000_07FF, "R7");
    tick(2);
    check_irq(1'b1, "R8");

    // R5 write-one-to-clear
    reg_write(2'd1, 32'h0000_0001);
    reg_read(2'd0, 32'h0000_0804, "R5");
    reg_write(2'd1, 32'hFFFF_F804);
    reg_read(2'd0, 32'h0000_0800, "R5");
    tick(2);
    check_irq(1'b0, "R8");

    // R6 set and clear of bit 3 in one cycle
    evt = 10'h008; wr = 1'b1; addr = 2'd1; wdata = 32'h0000_0008;
    @(negedge clk);
    evt = '0; wr = 1'b0; wdata = '0;
    reg_read(2'd0, 32'h0000_0808, "R6");
    reg_write(2'd1, 32'h0000_07FF);

    // R3 card insertion flags a change
    cd = 1'b0;
    tick(5);
    reg_read(2'd0, 32'h0000_0400, "R3");
    check_irq(1'b1, "R8");
    reg_write(2'd1, 32'h0000_0400);
    reg_read(2'd0, 32'h0000_0000, "R5");
    tick(1);
    check_irq(1'b0, "R8");

    // R4 write-protect live level, R10 it raises no interrupt
    wp = 1'b1;
    tick(4);
    reg_read(2'd0, 32'h0000_1000, "R4");
    tick(1);
    check_irq(1'b0, "R10");

    // R3 card removal flags a change too
    cd = 1'b1;
    tick(5);
    reg_read(2'd0, 32'h0000_1C00, "R3");
    reg_write(2'd1, 32'h0000_0400);
    reg_read(2'd0, 32'h0000_1800, "R4");

    // R9 clear word and unused word read zero
    reg_read(2'd1, 32'h0000_0000, "R9");
    reg_read(2'd3, 32'h0000_0000, "R9");

    // R8 selective mask
    reg_write(2'd2, 32'h0000_0200);
    pulse(10'h100);
    tick(2);
    check_irq(1'b0, "R8");
    pulse(10'h200);
    tick(2);
    check_irq(1'b1, "R8");
    reg_write(2'd2, 32'h0000_0000);
    tick(2);
    check_irq(1'b0, "R8");
    reg_read(2'd0, 32'h0000_1B00, "R2");

    // R2 every source bit on its own
    for (int k = 0; k < 10; k++) begin
      reg_write(2'd1, 32'h0000_07FF);
      pulse(10'(1 << k));
      reg_read(2'd0, 32'h0000_1800 | (32'h1 << k), "R2");
    end

    tick(3);
    if (exp_q.size() != 0) begin
      total++;
      bad++;
      $display("FAIL R9: %0d reads unanswered, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule